// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block keeps a single line reservation for a load-linked / store-conditional pair and judges whether each store-conditional succeeds. It watches the write path at completion time. Each completed operation comes with a line address, a requester ID and a kind: locked read, locked write or plain write. A completed locked read takes the reservation for its line and records its owner. A completed locked write is reported on a one-cycle result strobe with a pass or fail bit. The reservation is then released.

There is an external clear input with a line address. It stands for coherence invalidation or eviction of the reserved line. When its line matches the reservation, the reservation is dropped. The reservation state is also visible on output ports, so neighbouring logic and the bench can see it.

Top module: `ll_resv_monitor`

## Requirements
- R1: After reset there is no reservation (`resv_valid` = 0) and `sc_done` and `sc_pass` are low.
- R2: A completed locked read (`cmp_kind` = 2'b01) sets the reservation on the next cycle to its line and requester, replacing any earlier reservation.
- R3: A completed locked write (`cmp_kind` = 2'b10) passes (`sc_pass` = 1) only in these conditions:
  - a reservation is valid;
  - its line and owner equal the write's line and requester;
  - the clear input does not hit that line in the same cycle.
  Otherwise `sc_pass` = 0.
- R4: `sc_done` is high in exactly the cycles that carry a completed locked write, and `sc_pass` is never high without `sc_done`.
- R5: After a completed locked write to the reserved line, the reservation is gone on the next cycle, whether the write passed or failed and whichever requester issued it.
- R6: A completed locked write to a different line leaves the reservation unchanged.
- R7: A completed plain write (`cmp_kind` = 2'b11) clears the reservation only when both its line and its requester match the reservation. Otherwise the reservation is unchanged.
- R8: `clr_valid` with `clr_line` equal to the reserved line drops the reservation on the next cycle. A clear for another line has no effect.
- R9: Cycles with `cmp_valid` low, or with `cmp_kind` = 2'b00, change nothing. A locked read that coincides with a clear still installs its new reservation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_valid | input | 1 | A write-path operation completes this cycle |
| cmp_kind | input | 2 | 00 none, 01 locked read, 10 locked write, 11 plain write |
| cmp_line | input | LINE_W | Line address of the completing operation |
| cmp_agent | input | AGENT_W | Requester ID of the completing operation |
| clr_valid | input | 1 | External invalidation/eviction of a line |
| clr_line | input | LINE_W | Line address being invalidated |
| sc_done | output | 1 | Locked-write result strobe |
| sc_pass | output | 1 | Locked-write result: 1 success, 0 failure |
| resv_valid | output | 1 | Reservation held |
| resv_line | output | LINE_W | Reserved line |
| resv_agent | output | AGENT_W | Owner of the reservation |

## Verification
The assertions assume these things about the inputs:
- at most one operation completes per cycle;
- `cmp_kind` is read only when `cmp_valid` is high;
- a clear and a completion may coincide.

The random stimulus picks lines and requesters from a set of four values each. This keeps address and owner matches, and clear/locked-write collisions, frequent. It sometimes drives `cmp_kind` to 00 while `cmp_valid` is high, and leaves the kind set to an arbitrary value while `cmp_valid` is low.

// File: rtl/ll_resv_pkg.sv
package ll_resv_pkg;

    typedef enum logic [1:0] {
        OP_IDLE     = 2'b00,
        OP_LOCK_RD  = 2'b01,
        OP_LOCK_WR  = 2'b10,
        OP_PLAIN_WR = 2'b11
    } op_kind_e;

    function automatic logic op_is(input logic v, input logic [1:0] kind, input op_kind_e want);
        return v && (op_kind_e'(kind) == want);
    endfunction

endpackage

// File: rtl/resv_match.sv
module resv_match #(
    parameter int LINE_W  = 26,
    parameter int AGENT_W = 4
) (
    input  logic               held_valid,
    input  logic [LINE_W-1:0]  held_line,
    input  logic [AGENT_W-1:0] held_agent,
    input  logic [LINE_W-1:0]  req_line,
    input  logic [AGENT_W-1:0] req_agent,
    output logic               line_hit,
    output logic               owner_hit
);
    always_comb begin
        line_hit  = held_valid && (held_line == req_line);
        owner_hit = line_hit && (held_agent == req_agent);
    end
endmodule

// File: rtl/resv_store.sv
module resv_store #(
    parameter int LINE_W  = 26,
    parameter int AGENT_W = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               set_en,
    input  logic [LINE_W-1:0]  set_line,
    input  logic [AGENT_W-1:0] set_agent,
    input  logic               drop_en,
    output logic               held_valid,
    output logic [LINE_W-1:0]  held_line,
    output logic [AGENT_W-1:0] held_agent
);
    always_ff @(posedge clk) begin
        if (rst) begin
            held_valid <= 1'b0;
            held_line  <= '0;
            held_agent <= '0;
        end else if (set_en) begin
            held_valid <= 1'b1;
            held_line  <= set_line;
            held_agent <= set_agent;
        end else if (drop_en) begin
            held_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/ll_resv_monitor.sv
module ll_resv_monitor
    import ll_resv_pkg::*;
#(
    parameter int LINE_W  = 26,
    parameter int AGENT_W = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cmp_valid,
    input  logic [1:0]         cmp_kind,
    input  logic [LINE_W-1:0]  cmp_line,
    input  logic [AGENT_W-1:0] cmp_agent,
    input  logic               clr_valid,
    input  logic [LINE_W-1:0]  clr_line,
    output logic               sc_done,
    output logic               sc_pass,
    output logic               resv_valid,
    output logic [LINE_W-1:0]  resv_line,
    output logic [AGENT_W-1:0] resv_agent
);
    logic is_lr, is_lw, is_pw;
    logic op_line_hit, op_owner_hit, clr_hit;
    logic set_en, drop_en;

    always_comb begin
        is_lr = op_is(cmp_valid, cmp_kind, OP_LOCK_RD);
        is_lw = op_is(cmp_valid, cmp_kind, OP_LOCK_WR);
        is_pw = op_is(cmp_valid, cmp_kind, OP_PLAIN_WR);
    end

    resv_match #(.LINE_W(LINE_W), .AGENT_W(AGENT_W)) u_match (
        .held_valid (resv_valid),
        .held_line  (resv_line),
        .held_agent (resv_agent),
        .req_line   (cmp_line),
        .req_agent  (cmp_agent),
        .line_hit   (op_line_hit),
        .owner_hit  (op_owner_hit)
    );

    // external invalidation compares only the line
    assign clr_hit = clr_valid && resv_valid && (clr_line == resv_line);

    always_comb begin
        sc_done = is_lw;
        sc_pass = is_lw && op_owner_hit && !clr_hit;
        set_en  = is_lr;
        drop_en = clr_hit || (is_lw && op_line_hit) || (is_pw && op_owner_hit);
    end

    resv_store #(.LINE_W(LINE_W), .AGENT_W(AGENT_W)) u_store (
        .clk        (clk),
        .rst        (rst),
        .set_en     (set_en),
        .set_line   (cmp_line),
        .set_agent  (cmp_agent),
        .drop_en    (drop_en),
        .held_valid (resv_valid),
        .held_line  (resv_line),
        .held_agent (resv_agent)
    );
endmodule

// File: rtl/ll_resv_monitor_chk.sv
module ll_resv_monitor_chk #(
    parameter int LINE_W  = 26,
    parameter int AGENT_W = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               cmp_valid,
    input logic [1:0]         cmp_kind,
    input logic [LINE_W-1:0]  cmp_line,
    input logic [AGENT_W-1:0] cmp_agent,
    input logic               clr_valid,
    input logic [LINE_W-1:0]  clr_line,
    input logic               sc_done,
    input logic               sc_pass,
    input logic               resv_valid,
    input logic [LINE_W-1:0]  resv_line,
    input logic [AGENT_W-1:0] resv_agent
);
    logic lr, lw, pw, quiet;
    assign lr    = cmp_valid && cmp_kind == 2'b01;
    assign lw    = cmp_valid && cmp_kind == 2'b10;
    assign pw    = cmp_valid && cmp_kind == 2'b11;
    assign quiet = !clr_valid && (!cmp_valid || cmp_kind == 2'b00);

    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> !resv_valid);

    assert_lock_read_sets_R2: assert property (@(posedge clk) disable iff (rst)
        lr |=> resv_valid && resv_line == $past(cmp_line) && resv_agent == $past(cmp_agent));

    assert_pass_needs_owner_R3: assert property (@(posedge clk) disable iff (rst)
        sc_pass |-> resv_valid && resv_line == cmp_line && resv_agent == cmp_agent);

    assert_pass_within_done_R4: assert property (@(posedge clk) disable iff (rst)
        sc_pass |-> sc_done);

    assert_done_tracks_lw_R4: assert property (@(posedge clk) disable iff (rst)
        sc_done == lw);

    assert_lw_clears_R5: assert property (@(posedge clk) disable iff (rst)
        lw && resv_valid && resv_line == cmp_line |=> !resv_valid);

    assert_owner_write_clears_R7: assert property (@(posedge clk) disable iff (rst)
        pw && resv_valid && resv_line == cmp_line && resv_agent == cmp_agent |=> !resv_valid);

    assert_clear_hit_drops_R8: assert property (@(posedge clk) disable iff (rst)
        clr_valid && resv_valid && clr_line == resv_line && !lr |=> !resv_valid);

    assert_clear_hit_fails_sc_R8: assert property (@(posedge clk) disable iff (rst)
        clr_valid && resv_valid && clr_line == resv_line |-> !sc_pass);

    assert_quiet_stable_R9: assert property (@(posedge clk) disable iff (rst)
        quiet |=> $stable(resv_valid) && $stable(resv_line) && $stable(resv_agent));
endmodule

bind ll_resv_monitor ll_resv_monitor_chk #(.LINE_W(LINE_W), .AGENT_W(AGENT_W)) u_chk (.*);

// File: tb/ll_resv_monitor_tb.sv
`timescale 1ns/1ps
module ll_resv_monitor_tb;
    localparam int LINE_W  = 26;
    localparam int AGENT_W = 4;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               cmp_valid = 1'b0;
    logic [1:0]         cmp_kind = 2'b00;
    logic [LINE_W-1:0]  cmp_line = '0;
    logic [AGENT_W-1:0] cmp_agent = '0;
    logic               clr_valid = 1'b0;
    logic [LINE_W-1:0]  clr_line = '0;
    logic               sc_done, sc_pass, resv_valid;
    logic [LINE_W-1:0]  resv_line;
    logic [AGENT_W-1:0] resv_agent;

    int checks = 0;
    int fails  = 0;

    logic               m_v = 1'b0;
    logic [LINE_W-1:0]  m_l = '0;
    logic [AGENT_W-1:0] m_a = '0;

    always #2.5 clk = ~clk;

    ll_resv_monitor #(.LINE_W(LINE_W), .AGENT_W(AGENT_W)) u_dut (
        .clk(clk), .rst(rst), .cmp_valid(cmp_valid), .cmp_kind(cmp_kind),
        .cmp_line(cmp_line), .cmp_agent(cmp_agent), .clr_valid(clr_valid),
        .clr_line(clr_line), .sc_done(sc_done), .sc_pass(sc_pass),
        .resv_valid(resv_valid), .resv_line(resv_line), .resv_agent(resv_agent)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic exp_pass(input logic v, input logic [1:0] k, input logic [LINE_W-1:0] l,
                                      input logic [AGENT_W-1:0] a, input logic cv,
                                      input logic [LINE_W-1:0] cl);
        return v && k == 2'b10 && m_v && l == m_l && a == m_a && !(cv && cl == m_l);
    endfunction

    // one cycle: drive after a falling edge, check outputs, then check state after the rising edge
    task automatic step(input logic v, input logic [1:0] k, input logic [LINE_W-1:0] l,
                        input logic [AGENT_W-1:0] a, input logic cv, input logic [LINE_W-1:0] cl);
        logic n_v; logic [LINE_W-1:0] n_l; logic [AGENT_W-1:0] n_a;
        string tag;
        cmp_valid = v; cmp_kind = k; cmp_line = l; cmp_agent = a;
        clr_valid = cv; clr_line = cl;
        #1;
        chk("R4 sc_done", sc_done, v && k == 2'b10);
        chk("R3 sc_pass", sc_pass, exp_pass(v, k, l, a, cv, cl));
        n_v = m_v; n_l = m_l; n_a = m_a;
        tag = "R9 state";
        if (cv && m_v && cl == m_l) begin n_v = 1'b0; tag = "R8 state"; end
        else if (cv) tag = "R8 miss state";
        if (v && k == 2'b10) begin
            if (m_v && l == m_l) begin n_v = 1'b0; tag = "R5 state"; end
            else tag = "R6 state";
        end
        if (v && k == 2'b11) begin
            if (m_v && l == m_l && a == m_a) n_v = 1'b0;
            tag = "R7 state";
        end
        if (v && k == 2'b01) begin n_v = 1'b1; n_l = l; n_a = a; tag = "R2 state"; end
        @(negedge clk);
        chk(tag, {resv_valid, resv_line, resv_agent},
            {n_v, (n_v ? n_l : resv_line), (n_v ? n_a : resv_agent)});
        m_v = n_v; m_l = n_l; m_a = n_a;
    endtask

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog expired");
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 resv_valid", resv_valid, 1'b0);
        chk("R1 sc_done", sc_done, 1'b0);
        chk("R1 sc_pass", sc_pass, 1'b0);
        rst = 1'b0;

        // directed: reserve, successful store-conditional
        step(1, 2'b01, 26'h5, 4'h2, 0, 0);
        step(1, 2'b10, 26'h5, 4'h2, 0, 0);
        // failing store-conditional without a reservation
        step(1, 2'b10, 26'h5, 4'h2, 0, 0);
        // other agent's SC to reserved line: fails and clears
        step(1, 2'b01, 26'h7, 4'h1, 0, 0);
        step(1, 2'b10, 26'h7, 4'h3, 0, 0);
        // SC to other line keeps reservation (R6)
        step(1, 2'b01, 26'h7, 4'h1, 0, 0);
        step(1, 2'b10, 26'h8, 4'h1, 0, 0);
        // plain write by other agent keeps, by owner clears (R7)
        step(1, 2'b11, 26'h7, 4'h2, 0, 0);
        step(1, 2'b11, 26'h7, 4'h1, 0, 0);
        // clear coinciding with SC: fails (R8)
        step(1, 2'b01, 26'h9, 4'h4, 0, 0);
        step(0, 2'b10, 26'h9, 4'h4, 1, 26'h3);
        step(1, 2'b10, 26'h9, 4'h4, 1, 26'h9);
        // idle kind and locked read with clear (R9)
        step(1, 2'b01, 26'h2, 4'h6, 0, 0);
        step(1, 2'b00, 26'h2, 4'h6, 0, 0);
        step(1, 2'b01, 26'h3, 4'h5, 1, 26'h2);
        // replacement by a new locked read (R2)
        step(1, 2'b01, 26'h1, 4'h7, 0, 0);

        for (int i = 0; i < 2000; i++) begin
            step($urandom_range(0, 3) != 0, 2'($urandom_range(0, 3)),
                 LINE_W'($urandom_range(0, 3)), AGENT_W'($urandom_range(0, 3)),
                 $urandom_range(0, 5) == 0, LINE_W'($urandom_range(0, 3)));
        end

        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule